// File: doc/BRIEF.md
# Direct-Mapped Cache Controller with Critical-Word-First Refill

This block sits between a processor request port and a word-wide external memory port. Every accepted request is checked against a small store of tags with one valid bit per line. Read hits are answered from local storage without touching memory. A read miss refills the whole line. The word that was asked for is fetched first and handed to the processor as soon as it arrives. The remaining words follow in the background, in wrap-around order.

Partial writes are write-through with no allocation. A write that supplies a whole line in one request allocates the line directly and sends all four words to memory, without first reading the old contents. While a transaction is in progress, the processor-side ready signal stays low, so a new request waits until the refill or write has fully finished.

Top module: `dm_cache_ctrl`

## Requirements
- R1: Reset (synchronous, active high) leaves every line invalid, `cpu_ready` high, and `cpu_rvalid` and `mem_req` low.
- R2: A 32-bit byte address splits into a word offset in bits [3:2], a line index in bits [5:4] and a tag in bits [31:6]. The cache holds 4 lines of 4 32-bit words.
- R3: A read whose line is valid with a matching tag issues no memory request. The stored word is returned with a one-cycle `cpu_rvalid` pulse two clock edges after acceptance.
- R4: A read miss issues exactly four memory reads in the requested line. The first read is the requested word, followed by offsets +1, +2 and +3 modulo 4.
- R5: On a read miss, `cpu_rvalid` pulses with the requested word right after the first memory acknowledge, before the other three words have been read.
- R6: A miss to a valid line holding another tag replaces that line. Alternating reads of 0x40 and 0x80 therefore miss every time.
- R7: A request is accepted only when `cpu_valid` and `cpu_ready` are both high. `cpu_ready` stays low from acceptance until the last memory transfer of that request has been acknowledged.
- R8: A partial write (`cpu_we`=1, `cpu_line`=0) that hits updates the cached word and makes one memory write to the same address.
- R9: A partial write that misses makes one memory write and leaves the cache unchanged, so a later read of that address misses.
- R10: A whole-line write (`cpu_we`=1, `cpu_line`=1, word k in `cpu_line_wdata[32k+31:32k]`, address bits [3:0] ignored) makes four memory writes at offsets 0 to 3 in that order. It makes no memory read and leaves the line valid with the new tag and data.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_addr` and `mem_we` hold steady. A transfer completes only on a cycle with both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_valid | input | 1 | Processor request present |
| cpu_ready | output | 1 | Controller idle, request can be taken |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_line | input | 1 | With cpu_we, request writes a whole line |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data for partial writes |
| cpu_line_wdata | input | 128 | Line data for whole-line writes, word 0 lowest |
| cpu_rvalid | output | 1 | Read data valid pulse |
| cpu_rdata | output | 32 | Read data |
| mem_req | output | 1 | Memory transfer requested |
| mem_we | output | 1 | Memory transfer is a write |
| mem_addr | output | 32 | Word-aligned memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory accepts the transfer; read data valid |
| mem_rdata | input | 32 | Memory read data |

## Verification
The hardest situation to reach from the ports is the window inside a refill: the requested word has already been forwarded, but the line is not yet valid. Observing that the critical word arrives before the rest of the line needs a memory that answers slowly. The bench model therefore inserts wait cycles between acknowledges, and it records how many reads had completed when the data pulse was seen. Wrap-around order is exercised by misses at offsets 1, 2 and 3. Replacement is exercised by the 0x40/0x80 ping-pong. Whole-line allocation is exercised over a line already holding another tag.

// File: rtl/dmc_pkg.sv
package dmc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOK,
    ST_FILL,
    ST_WTHRU,
    ST_LINEWR
  } dmc_state_e;
endpackage

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
  parameter int LINES = 4,
  parameter int TAG_W = 26,
  parameter int IDX_W = $clog2(LINES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] look_idx,
  input  logic [TAG_W-1:0] look_tag,
  output logic             look_hit,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag
);
  logic [LINES-1:0] valid_q;
  logic [TAG_W-1:0] tag_q [LINES];

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= '0;
    end else if (set_en) begin
      valid_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) begin
      tag_q[set_idx] <= set_tag;
    end
  end

  assign look_hit = valid_q[look_idx] && (tag_q[look_idx] == look_tag);
endmodule

// File: rtl/dmc_data_ram.sv
module dmc_data_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  parameter int AW     = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
    if (re) begin
      rdata <= mem_q[raddr];
    end
  end
endmodule

// File: rtl/dm_cache_ctrl.sv
module dm_cache_ctrl
  import dmc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LINES  = 4,
  parameter int WORDS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cpu_valid,
  output logic                    cpu_ready,
  input  logic                    cpu_we,
  input  logic                    cpu_line,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  input  logic [DATA_W*WORDS-1:0] cpu_line_wdata,
  output logic                    cpu_rvalid,
  output logic [DATA_W-1:0]       cpu_rdata,
  output logic                    mem_req,
  output logic                    mem_we,
  output logic [ADDR_W-1:0]       mem_addr,
  output logic [DATA_W-1:0]       mem_wdata,
  input  logic                    mem_ack,
  input  logic [DATA_W-1:0]       mem_rdata
);
  localparam int BYTE_W  = $clog2(DATA_W / 8);
  localparam int OFF_W   = $clog2(WORDS);
  localparam int IDX_W   = $clog2(LINES);
  localparam int IDX_LSB = BYTE_W + OFF_W;
  localparam int TAG_LSB = IDX_LSB + IDX_W;
  localparam int TAG_W   = ADDR_W - TAG_LSB;
  localparam int RAM_AW  = IDX_W + OFF_W;
  localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

  dmc_state_e state_q;
  logic [TAG_W-1:0]        tag_q;
  logic [IDX_W-1:0]        idx_q;
  logic [OFF_W-1:0]        off_q;
  logic [OFF_W-1:0]        cnt_q;
  logic                    we_q;
  logic [DATA_W-1:0]       wdata_q;
  logic [DATA_W*WORDS-1:0] line_q;

  logic [TAG_W-1:0]  req_tag;
  logic [IDX_W-1:0]  req_idx;
  logic [OFF_W-1:0]  req_off;
  logic              lsb_unused;
  logic              accept;
  logic              xfer;
  logic              hit;
  logic [OFF_W-1:0]  off_cur;
  logic [OFF_W-1:0]  fill_nxt;
  logic [OFF_W-1:0]  cnt_nxt;
  logic              tag_set;
  logic              ram_we;
  logic [RAM_AW-1:0] ram_waddr;
  logic [DATA_W-1:0] ram_wdata;
  logic [DATA_W-1:0] ram_rdata;

  assign req_tag    = cpu_addr[ADDR_W-1:TAG_LSB];
  assign req_idx    = cpu_addr[TAG_LSB-1:IDX_LSB];
  assign req_off    = cpu_addr[IDX_LSB-1:BYTE_W];
  assign lsb_unused = ^cpu_addr[BYTE_W-1:0];

  assign cpu_ready = (state_q == ST_IDLE);
  assign accept    = cpu_valid && cpu_ready;
  assign xfer      = mem_req && mem_ack;
  assign off_cur   = off_q + cnt_q;
  assign fill_nxt  = off_cur + 1'b1;
  assign cnt_nxt   = cnt_q + 1'b1;
  assign tag_set   = xfer && (cnt_q == LAST) &&
                     (state_q == ST_FILL || state_q == ST_LINEWR);

  function automatic logic [ADDR_W-1:0] word_addr(input logic [OFF_W-1:0] o);
    return {tag_q, idx_q, o, {BYTE_W{1'b0}}};
  endfunction

  dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
    .clk      (clk),
    .rst      (rst),
    .look_idx (idx_q),
    .look_tag (tag_q),
    .look_hit (hit),
    .set_en   (tag_set),
    .set_idx  (idx_q),
    .set_tag  (tag_q)
  );

  dmc_data_ram #(.DEPTH(LINES * WORDS), .DATA_W(DATA_W), .AW(RAM_AW)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .re    (accept),
    .raddr ({req_idx, req_off}),
    .rdata (ram_rdata)
  );

  always_comb begin
    ram_we    = 1'b0;
    ram_waddr = {idx_q, off_cur};
    ram_wdata = mem_rdata;
    case (state_q)
      ST_LOOK: begin
        if (we_q && hit) begin
          ram_we    = 1'b1;
          ram_waddr = {idx_q, off_q};
          ram_wdata = wdata_q;
        end
      end
      ST_FILL: ram_we = xfer;
      ST_LINEWR: begin
        ram_we    = xfer;
        ram_waddr = {idx_q, cnt_q};
        ram_wdata = line_q[cnt_q*DATA_W +: DATA_W];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      mem_req    <= 1'b0;
      mem_we     <= 1'b0;
      cpu_rvalid <= 1'b0;
      cnt_q      <= '0;
    end else begin
      cpu_rvalid <= 1'b0;
      case (state_q)
        ST_IDLE: begin
          if (accept) begin
            tag_q   <= req_tag;
            idx_q   <= req_idx;
            off_q   <= req_off;
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
            line_q  <= cpu_line_wdata;
            cnt_q   <= '0;
            if (cpu_we && cpu_line) begin
              off_q     <= '0;
              mem_req   <= 1'b1;
              mem_we    <= 1'b1;
              mem_addr  <= {req_tag, req_idx, {OFF_W{1'b0}}, {BYTE_W{1'b0}}};
              mem_wdata <= cpu_line_wdata[DATA_W-1:0];
              state_q   <= ST_LINEWR;
            end else begin
              state_q <= ST_LOOK;
            end
          end
        end
        ST_LOOK: begin
          if (!we_q && hit) begin
            cpu_rvalid <= 1'b1;
            cpu_rdata  <= ram_rdata;
            state_q    <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= we_q;
            mem_addr  <= word_addr(off_q);
            mem_wdata <= wdata_q;
            state_q   <= we_q ? ST_WTHRU : ST_FILL;
          end
        end
        ST_WTHRU: begin
          if (xfer) begin
            mem_req <= 1'b0;
            state_q <= ST_IDLE;
          end
        end
        ST_FILL: begin
          if (xfer) begin
            if (cnt_q == '0) begin
              cpu_rvalid <= 1'b1;
              cpu_rdata  <= mem_rdata;
            end
            if (cnt_q == LAST) begin
              mem_req <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q    <= cnt_nxt;
              mem_addr <= word_addr(fill_nxt);
            end
          end
        end
        ST_LINEWR: begin
          if (xfer) begin
            if (cnt_q == LAST) begin
              mem_req <= 1'b0;
              state_q <= ST_IDLE;
            end else begin
              cnt_q     <= cnt_nxt;
              mem_addr  <= word_addr(cnt_nxt);
              mem_wdata <= line_q[cnt_nxt*DATA_W +: DATA_W];
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
  parameter int ADDR_W   = 32,
  parameter int WORD_LSB = 2,
  parameter int LINE_LSB = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_valid,
  input logic              cpu_ready,
  input logic [ADDR_W-1:0] cpu_addr,
  input logic              cpu_rvalid,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ack
);
  logic [ADDR_W-1:WORD_LSB] req_q;
  logic                     chk_unused;

  assign chk_unused = ^{cpu_addr[WORD_LSB-1:0], mem_addr[WORD_LSB-1:0]};

  always_ff @(posedge clk) begin
    if (cpu_valid && cpu_ready) begin
      req_q <= cpu_addr[ADDR_W-1:WORD_LSB];
    end
  end

  // R1
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> (!mem_req && !cpu_rvalid && cpu_ready));

  // R7
  busy_stall_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !cpu_ready);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R4
  critical_first_chk: assert property (@(posedge clk) disable iff (rst)
    ($rose(mem_req) && !mem_we) |-> (mem_addr[ADDR_W-1:WORD_LSB] == req_q));

  // R4
  fill_in_line_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_addr[ADDR_W-1:LINE_LSB] == req_q[ADDR_W-1:LINE_LSB]));
endmodule

bind dm_cache_ctrl dmc_checker #(
  .ADDR_W   (ADDR_W),
  .WORD_LSB (BYTE_W),
  .LINE_LSB (IDX_LSB)
) u_dmc_chk (
  .clk        (clk),
  .rst        (rst),
  .cpu_valid  (cpu_valid),
  .cpu_ready  (cpu_ready),
  .cpu_addr   (cpu_addr),
  .cpu_rvalid (cpu_rvalid),
  .mem_req    (mem_req),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_ack    (mem_ack)
);

// File: tb/test_dm_cache_ctrl.sv
module test_dm_cache_ctrl;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         cpu_valid = 1'b0;
  logic         cpu_ready;
  logic         cpu_we = 1'b0;
  logic         cpu_line = 1'b0;
  logic [31:0]  cpu_addr = '0;
  logic [31:0]  cpu_wdata = '0;
  logic [127:0] cpu_line_wdata = '0;
  logic         cpu_rvalid;
  logic [31:0]  cpu_rdata;
  logic         mem_req;
  logic         mem_we;
  logic [31:0]  mem_addr;
  logic [31:0]  mem_wdata;
  logic         mem_ack = 1'b0;
  logic [31:0]  mem_rdata = '0;

  always #10 clk = ~clk;

  dm_cache_ctrl i_dm_cache_ctrl (
    .clk(clk), .rst(rst), .cpu_valid(cpu_valid), .cpu_ready(cpu_ready),
    .cpu_we(cpu_we), .cpu_line(cpu_line), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_line_wdata(cpu_line_wdata),
    .cpu_rvalid(cpu_rvalid), .cpu_rdata(cpu_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  // external memory model: words initialised to C0DE0000 + word index
  logic [31:0] ext_mem [256];
  logic [31:0] log_addr [16];
  int log_n = 0, n_rd = 0, n_wr = 0, gap_n = 1, gap_ctr = 0;
  int checks = 0, errors = 0;
  bit done = 0;

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack = 1'b0;
    end else if (mem_req) begin
      if (gap_ctr < gap_n) begin
        gap_ctr++;
      end else begin
        gap_ctr = 0;
        mem_ack = 1'b1;
        if (mem_we) begin
          ext_mem[mem_addr[9:2]] = mem_wdata;
          n_wr++;
        end else begin
          mem_rdata = ext_mem[mem_addr[9:2]];
          n_rd++;
        end
        if (log_n < 16) log_addr[log_n] = mem_addr;
        log_n++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic xact(input bit we, input bit line, input logic [31:0] addr,
                      input logic [31:0] wd, input logic [127:0] lw,
                      output logic [31:0] rd, output bit got, output int rd_at);
    bit fin = 0;
    got = 0; rd = '0; rd_at = -1;
    log_n = 0; n_rd = 0; n_wr = 0;
    @(posedge clk); #5;
    cpu_valid = 1'b1; cpu_we = we; cpu_line = line;
    cpu_addr = addr; cpu_wdata = wd; cpu_line_wdata = lw;
    @(posedge clk); #5;
    cpu_valid = 1'b0;
    for (int k = 0; k < 200; k++) begin
      if (cpu_rvalid) begin
        got = 1; rd = cpu_rdata; rd_at = n_rd;
      end
      if (cpu_ready) begin
        fin = 1;
        break;
      end
      @(posedge clk); #5;
    end
    chk(fin, "R7", "transaction finished", 32'(fin), 32'd1);
  endtask

  task automatic do_reset();
    @(posedge clk); #5;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #5;
    rst = 1'b0;
  endtask

  typedef struct packed {
    logic        we;
    logic [31:0] addr;
    logic [31:0] wd;
    logic [31:0] exp_rd;
    logic [3:0]  exp_nrd;
    logic [3:0]  exp_nwr;
    logic [31:0] exp_first;
  } vec_t;

  localparam vec_t VECS [11] = '{
    '{1'b0, 32'h44, 32'h0,        32'hC0DE0011, 4'd4, 4'd0, 32'h44},
    '{1'b0, 32'h4C, 32'h0,        32'hC0DE0013, 4'd0, 4'd0, 32'h0},
    '{1'b0, 32'h80, 32'h0,        32'hC0DE0020, 4'd4, 4'd0, 32'h80},
    '{1'b0, 32'h40, 32'h0,        32'hC0DE0010, 4'd4, 4'd0, 32'h40},
    '{1'b0, 32'h84, 32'h0,        32'hC0DE0021, 4'd4, 4'd0, 32'h84},
    '{1'b1, 32'h88, 32'h12345678, 32'h0,        4'd0, 4'd1, 32'h88},
    '{1'b0, 32'h88, 32'h0,        32'h12345678, 4'd0, 4'd0, 32'h0},
    '{1'b1, 32'h54, 32'hDEADBEEF, 32'h0,        4'd0, 4'd1, 32'h54},
    '{1'b0, 32'h54, 32'h0,        32'hDEADBEEF, 4'd4, 4'd0, 32'h54},
    '{1'b0, 32'h5C, 32'h0,        32'hC0DE0017, 4'd0, 4'd0, 32'h0},
    '{1'b0, 32'h3C, 32'h0,        32'hC0DE000F, 4'd4, 4'd0, 32'h3C}
  };
  localparam string VEC_REQ [11] = '{"R4", "R3", "R6", "R6", "R6", "R8",
                                     "R8", "R9", "R9", "R3", "R2"};

  function automatic logic [127:0] mk_line(input logic [31:0] base);
    return {base + 32'd3, base + 32'd2, base + 32'd1, base};
  endfunction

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    bit got;
    int rd_at;
    for (int i = 0; i < 256; i++) ext_mem[i] = 32'hC0DE0000 + i;

    repeat (3) @(posedge clk);
    #5;
    rst = 1'b0;
    // R1: idle outputs after reset
    chk(cpu_ready == 1'b1, "R1", "cpu_ready", 32'(cpu_ready), 32'd1);
    chk(mem_req == 1'b0, "R1", "mem_req", 32'(mem_req), 32'd0);
    chk(cpu_rvalid == 1'b0, "R1", "cpu_rvalid", 32'(cpu_rvalid), 32'd0);

    for (int v = 0; v < 11; v++) begin
      xact(VECS[v].we, 1'b0, VECS[v].addr, VECS[v].wd, '0, rd, got, rd_at);
      if (!VECS[v].we) begin
        chk(got, VEC_REQ[v], "read data pulse", 32'(got), 32'd1);
        chk(rd == VECS[v].exp_rd, VEC_REQ[v], "read data", rd, VECS[v].exp_rd);
      end
      chk(n_rd == int'(VECS[v].exp_nrd), VEC_REQ[v], "memory reads",
          32'(n_rd), 32'(VECS[v].exp_nrd));
      chk(n_wr == int'(VECS[v].exp_nwr), VEC_REQ[v], "memory writes",
          32'(n_wr), 32'(VECS[v].exp_nwr));
      if (VECS[v].exp_nrd + VECS[v].exp_nwr != 0)
        chk(log_addr[0] == VECS[v].exp_first, VEC_REQ[v], "first memory address",
            log_addr[0], VECS[v].exp_first);
    end
    // R4: wrap order of the 0x3C fill
    chk(log_addr[1] == 32'h30, "R4", "wrap word 1", log_addr[1], 32'h30);
    chk(log_addr[3] == 32'h38, "R4", "wrap word 3", log_addr[3], 32'h38);

    // R5: critical word forwarded after one read, slow memory
    gap_n = 3;
    xact(1'b0, 1'b0, 32'h18, '0, '0, rd, got, rd_at);
    chk(rd == 32'hC0DE0006, "R5", "critical data", rd, 32'hC0DE0006);
    chk(rd_at == 1, "R5", "reads done at data pulse", 32'(rd_at), 32'd1);
    chk(log_addr[1] == 32'h1C && log_addr[2] == 32'h10 && log_addr[3] == 32'h14,
        "R4", "wrap order from offset 2", log_addr[2], 32'h10);
    // R11: slow handshake keeps the whole line intact
    xact(1'b0, 1'b0, 32'h14, '0, '0, rd, got, rd_at);
    chk(n_rd == 0 && rd == 32'hC0DE0005, "R11", "hit after slow fill", rd, 32'hC0DE0005);
    gap_n = 1;

    // R10: whole-line write, no reads, offsets 0..3
    xact(1'b1, 1'b1, 32'h68, '0, mk_line(32'h11110000), rd, got, rd_at);
    chk(n_rd == 0, "R10", "no memory reads", 32'(n_rd), 32'd0);
    chk(n_wr == 4, "R10", "memory writes", 32'(n_wr), 32'd4);
    chk(log_addr[0] == 32'h60 && log_addr[3] == 32'h6C, "R10", "write order",
        log_addr[0], 32'h60);
    xact(1'b0, 1'b0, 32'h68, '0, '0, rd, got, rd_at);
    chk(n_rd == 0 && rd == 32'h11110002, "R10", "allocated line hit", rd, 32'h11110002);
    // R10: whole-line write over a valid line with another tag
    xact(1'b1, 1'b1, 32'hA0, '0, mk_line(32'h22220000), rd, got, rd_at);
    xact(1'b0, 1'b0, 32'hA4, '0, '0, rd, got, rd_at);
    chk(n_rd == 0 && rd == 32'h22220001, "R10", "replaced line hit", rd, 32'h22220001);
    xact(1'b0, 1'b0, 32'h64, '0, '0, rd, got, rd_at);
    chk(n_rd == 4 && rd == 32'h11110001, "R6", "evicted line refetched", rd, 32'h11110001);

    // R1: reset invalidates lines
    do_reset();
    chk(cpu_ready == 1'b1 && mem_req == 1'b0, "R1", "idle after reset",
        32'(cpu_ready), 32'd1);
    xact(1'b0, 1'b0, 32'h64, '0, '0, rd, got, rd_at);
    chk(n_rd == 4, "R1", "miss after reset", 32'(n_rd), 32'd4);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule